// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block is a small sequential arithmetic engine. It adds with carry or subtracts with borrow on two 8-bit operands, an accumulator value and a second operand. It works either in plain binary or in packed BCD, where each byte holds two decimal digits. A one-cycle start pulse hands it the operands, the operation, the mode and the incoming carry flag. It later raises a one-cycle done pulse. With that pulse the result and the four condition flags (negative, overflow, zero, carry) are valid, and they stay unchanged until the next operation finishes.

Binary operations finish in a single cycle. Decimal operations take one extra cycle, so that the negative, overflow and zero flags describe the digit-corrected result and not the raw binary sum. The carry flag keeps one meaning for both operations: on subtraction a set carry means "no borrow", on input and on output. Operand fetch, register writeback and all non-arithmetic operations belong to the surrounding processor.

Top module: `dec_addsub_unit`

## Requirements
- R1: Binary addition (subtract=0, decimalMode=0) gives result = (accIn + operandIn + carryIn) mod 256, and flagC = 1 exactly when that sum exceeds 255.
- R2: Binary subtraction (subtract=1, decimalMode=0) gives result = (accIn - operandIn - (1 - carryIn)) mod 256, and flagC = 1 exactly when no borrow occurs (the true difference is not negative).
- R3: In binary mode, flagV is the two's-complement overflow of accIn + B' + carryIn, where B' is operandIn for addition and its bitwise inverse for subtraction. The overflow is 1 when accIn[7] equals B'[7] and result[7] differs from them.
- R4: Whenever done is 1, flagN equals result[7] and flagZ is 1 exactly when result is 0, in both modes.
- R5: Decimal addition of valid BCD digits gives the BCD encoding of (A + B + carryIn) mod 100, with flagC = 1 exactly when that sum exceeds 99.
- R6: Decimal subtraction of valid BCD digits gives the BCD encoding of (A - B - (1 - carryIn)) mod 100, with flagC = 1 exactly when the decimal difference is not negative.
- R7: In decimal mode, flagV is 1 when accIn[7] equals B'[7] (B' as in R3) and bit 7 of the corrected decimal result differs from them.
- R8: For a binary operation, done is 1 in the cycle right after the clock edge that samples start, and only for that cycle unless another operation follows at once.
- R9: For a decimal operation, done is 0 in the cycle after the sampling edge and 1 in the cycle after that, for exactly one cycle.
- R10: A start pulse that arrives while a decimal operation waits for its second cycle is ignored. No extra done follows, and the result of the running operation is not altered.
- R11: After reset, result, all flags and done are 0. Between operations, result and flags hold their last values and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the current inputs |
| subtract | input | 1 | 1 selects subtraction, 0 addition |
| decimalMode | input | 1 | 1 selects packed BCD arithmetic |
| accIn | input | 8 | Accumulator operand |
| operandIn | input | 8 | Second operand |
| carryIn | input | 1 | Carry flag in (inverted borrow for subtraction) |
| result | output | 8 | Result of the last finished operation |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag out (inverted borrow for subtraction) |
| done | output | 1 | One-cycle pulse when result and flags are valid |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the second cycle of a decimal operation. Only there can a correct design silently drop a request. The bench holds start high across both cycles of a decimal operation and offers different binary operands in the second cycle. It then checks that exactly one done appears, two cycles after the first request, and that it carries the decimal answer. The decimal sweeps cover every BCD accumulator value, both carry values, both operations and every third BCD operand, including the wrap cases 99+1 and 0-1.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadBin;    // capture binary result and all flags
    logic loadDec;    // capture corrected decimal digits and carry
    logic finishDec;  // derive N, V, Z from the corrected result
  } dpStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FIX  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell (
  input  logic       subtract,
  input  logic [3:0] aDigit,
  input  logic [3:0] bDigit,
  input  logic       carryIn,   // for subtraction: 1 means no borrow
  output logic [3:0] sumDigit,
  output logic       carryOut
);
  localparam logic [4:0] MAX_DIGIT = 5'd9;
  localparam logic [3:0] ADJUST    = 4'd6;

  logic [4:0] raw;

  always_comb begin
    if (subtract) begin
      raw = {1'b0, aDigit} - {1'b0, bDigit} - {4'b0, ~carryIn};
      if (raw[4]) begin
        sumDigit = raw[3:0] - ADJUST;
        carryOut = 1'b0;
      end else begin
        sumDigit = raw[3:0];
        carryOut = 1'b1;
      end
    end else begin
      raw = {1'b0, aDigit} + {1'b0, bDigit} + {4'b0, carryIn};
      if (raw > MAX_DIGIT) begin
        sumDigit = raw[3:0] + ADJUST;
        carryOut = 1'b1;
      end else begin
        sumDigit = raw[3:0];
        carryOut = 1'b0;
      end
    end
  end
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic             subtract,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operandIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] resultQ,
  output logic             nQ,
  output logic             vQ,
  output logic             zQ,
  output logic             cQ
);
  localparam int DIGITS = WIDTH / 4;
  localparam int MSB    = WIDTH - 1;

  // Binary path
  logic [WIDTH-1:0] effB;
  logic [WIDTH:0]   binSum;
  logic [WIDTH-1:0] binRes;
  logic             binOvf;

  assign effB   = subtract ? ~operandIn : operandIn;
  assign binSum = {1'b0, accIn} + {1'b0, effB} + {{WIDTH{1'b0}}, carryIn};
  assign binRes = binSum[WIDTH-1:0];
  assign binOvf = (accIn[MSB] == effB[MSB]) && (binRes[MSB] != accIn[MSB]);

  // Decimal path: chain of digit cells, least significant first
  logic [DIGITS:0]  digitCarry;
  logic [WIDTH-1:0] decRes;

  assign digitCarry[0] = carryIn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_cell u_cell (
      .subtract (subtract),
      .aDigit   (accIn[4*d +: 4]),
      .bDigit   (operandIn[4*d +: 4]),
      .carryIn  (digitCarry[d]),
      .sumDigit (decRes[4*d +: 4]),
      .carryOut (digitCarry[d+1])
    );
  end

  // Signs kept for the second decimal cycle
  logic signA;
  logic signB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      nQ      <= 1'b0;
      vQ      <= 1'b0;
      zQ      <= 1'b0;
      cQ      <= 1'b0;
      signA   <= 1'b0;
      signB   <= 1'b0;
    end else if (strobes.loadBin) begin
      resultQ <= binRes;
      cQ      <= binSum[WIDTH];
      nQ      <= binRes[MSB];
      zQ      <= (binRes == '0);
      vQ      <= binOvf;
    end else if (strobes.loadDec) begin
      resultQ <= decRes;
      cQ      <= digitCarry[DIGITS];
      signA   <= accIn[MSB];
      signB   <= effB[MSB];
    end else if (strobes.finishDec) begin
      nQ      <= resultQ[MSB];
      zQ      <= (resultQ == '0);
      vQ      <= (signA == signB) && (resultQ[MSB] != signA);
    end
  end
endmodule

// File: rtl/addsub_control.sv
module addsub_control
  import addsub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       decimalMode,
  output dpStrobes_t strobes,
  output logic       done,
  output logic       busy
);
  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (decimalMode) begin
            strobes.loadDec = 1'b1;
            stateNext       = ST_FIX;
          end else begin
            strobes.loadBin = 1'b1;
          end
        end
      end
      ST_FIX: begin
        strobes.finishDec = 1'b1;
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.loadBin | strobes.finishDec;
    end
  end

  assign busy = (state == ST_FIX);
endmodule

// File: rtl/dec_addsub_unit.sv
module dec_addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             subtract,
  input  logic             decimalMode,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operandIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagV,
  output logic             flagZ,
  output logic             flagC,
  output logic             done
);
  dpStrobes_t strobes;
  logic       busy;

  addsub_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .decimalMode (decimalMode),
    .strobes     (strobes),
    .done        (done),
    .busy        (busy)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .subtract  (subtract),
    .accIn     (accIn),
    .operandIn (operandIn),
    .carryIn   (carryIn),
    .resultQ   (result),
    .nQ        (flagN),
    .vQ        (flagV),
    .zQ        (flagZ),
    .cQ        (flagC)
  );
endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             decimalMode,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result,
  input logic             flagN,
  input logic             flagZ
);
  // R8
  bin_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !decimalMode && !busy) |=> done);

  // R9
  dec_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && decimalMode && !busy) |=> (!done ##1 done));

  // R10
  fix_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R10
  fix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(result));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagZ == (result == '0)));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagN == result[WIDTH-1]));
endmodule

bind dec_addsub_unit addsub_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .decimalMode (decimalMode),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .flagN       (flagN),
  .flagZ       (flagZ)
);

// File: tb/sim_dec_addsub_unit.sv
`timescale 1ns/1ps
module sim_dec_addsub_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       subtract = 1'b0;
  logic       decimalMode = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] operandIn = '0;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic       flagN, flagV, flagZ, flagC, done;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dec_addsub_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .subtract(subtract),
    .decimalMode(decimalMode), .accIn(accIn), .operandIn(operandIn),
    .carryIn(carryIn), .result(result), .flagN(flagN), .flagV(flagV),
    .flagZ(flagZ), .flagC(flagC), .done(done)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic checkBit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic checkAll(string tag, logic [7:0] eRes, logic eN, logic eV,
                          logic eZ, logic eC);
    checks++;
    if ({result, flagN, flagV, flagZ, flagC} !== {eRes, eN, eV, eZ, eC}) begin
      errors++;
      $display("FAIL %s: got res=%h NVZC=%b%b%b%b expected res=%h NVZC=%b%b%b%b",
               tag, result, flagN, flagV, flagZ, flagC, eRes, eN, eV, eZ, eC);
    end
  endtask

  function automatic int bcdVal(logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // Expected values from the requirements
  task automatic expect_op(bit sub, bit dec, logic [7:0] a, logic [7:0] b, bit c,
                           output logic [7:0] eRes, output logic eN, eV, eZ, eC);
    logic [7:0] effB;
    int v;
    effB = sub ? ~b : b;
    if (!dec) begin
      v    = int'(a) + int'(effB) + int'(c);
      eRes = 8'(v);
      eC   = (v > 255);
    end else if (!sub) begin
      v    = bcdVal(a) + bcdVal(b) + int'(c);
      eC   = (v > 99);
      eRes = toBcd(v % 100);
    end else begin
      v    = bcdVal(a) - bcdVal(b) - (1 - int'(c));
      eC   = (v >= 0);
      eRes = toBcd((v + 100) % 100);
    end
    eN = eRes[7];
    eZ = (eRes == 8'h00);
    eV = (a[7] == effB[7]) && (eRes[7] != a[7]);
  endtask

  // Called at a falling edge; returns at the falling edge where done is expected
  task automatic runOp(bit sub, bit dec, logic [7:0] a, logic [7:0] b, bit c);
    logic [7:0] eRes;
    logic eN, eV, eZ, eC;
    subtract = sub; decimalMode = dec; accIn = a; operandIn = b; carryIn = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dec) begin
      checkBit("R9 done low in first decimal cycle", done, 1'b0);
      @(negedge clk);
    end
    checkBit(dec ? "R9 decimal done" : "R8 binary done", done, 1'b1);
    expect_op(sub, dec, a, b, c, eRes, eN, eV, eZ, eC);
    if (!dec)     checkAll(sub ? "R2 R3 R4 binary sub" : "R1 R3 R4 binary add", eRes, eN, eV, eZ, eC);
    else if (sub) checkAll("R6 R7 R4 decimal sub", eRes, eN, eV, eZ, eC);
    else          checkAll("R5 R7 R4 decimal add", eRes, eN, eV, eZ, eC);
  endtask

  initial begin
    logic [7:0] held;
    logic [7:0] eRes;
    logic eN, eV, eZ, eC;
    repeat (3) @(negedge clk);
    // R11 reset state
    checkAll("R11 reset outputs", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    checkBit("R11 reset done", done, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // Corner cases
    runOp(1'b0, 1'b0, 8'h7F, 8'h00, 1'b1);   // R3 signed overflow to 0x80
    runOp(1'b0, 1'b0, 8'hFF, 8'h00, 1'b1);   // R1 wrap to zero, carry
    runOp(1'b1, 1'b0, 8'h80, 8'h01, 1'b1);   // R3 subtract overflow
    runOp(1'b1, 1'b0, 8'h00, 8'h00, 1'b0);   // R2 borrow in
    runOp(1'b0, 1'b1, 8'h99, 8'h00, 1'b1);   // R5 99+1 -> 00 carry
    runOp(1'b1, 1'b1, 8'h00, 8'h01, 1'b1);   // R6 0-1 -> 99 borrow
    runOp(1'b0, 1'b1, 8'h49, 8'h31, 1'b0);   // R7 decimal 80 sign change

    // R11 hold between operations
    held = result;
    repeat (3) @(negedge clk);
    checkBit("R11 done idle", done, 1'b0);
    checks++;
    if (result !== held) begin
      errors++;
      $display("FAIL R11 hold: got %h expected %h", result, held);
    end

    // R10 start during the second decimal cycle is ignored
    subtract = 1'b0; decimalMode = 1'b1; accIn = 8'h45; operandIn = 8'h38; carryIn = 1'b0;
    start = 1'b1;
    @(negedge clk);
    decimalMode = 1'b0; accIn = 8'h01; operandIn = 8'h02; // offered while busy
    checkBit("R10 no done while busy", done, 1'b0);
    @(negedge clk);
    start = 1'b0;
    checkBit("R10 decimal done", done, 1'b1);
    expect_op(1'b0, 1'b1, 8'h45, 8'h38, 1'b0, eRes, eN, eV, eZ, eC);
    checkAll("R10 result of running op", eRes, eN, eV, eZ, eC);
    @(negedge clk);
    checkBit("R10 no extra done", done, 1'b0);
    checkAll("R10 result unchanged", eRes, eN, eV, eZ, eC);

    // Binary sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 11)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            runOp(s[0], 1'b0, 8'(a), 8'(b), c[0]);

    // Decimal sweep over valid BCD values
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b += 3)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            runOp(s[0], 1'b1, toBcd(a), toBcd(b), c[0]);

    @(negedge clk);
    checkBit("R8 single done pulse", done, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule